// File: doc/BRIEF.md
# SD Card Data FIFO with Status Word

This block is the data staging buffer between a 32-bit software register port and the data transfer controller of an SD card host. It holds up to sixteen 32-bit words and is used in one direction at a time. In transmit, software pushes words and the controller pops them toward the card. In receive, the controller pushes words taken from the card and software pops them.

A combinational status word reports how full the buffer is, counted in bytes, together with direction-specific threshold flags. Software reads this word to work out how many whole words it can move without losing data. The word also carries a two-bit failure field for overflow and underrun, and a flag that marks the final word of a receive. A status write can flush the buffer; the flush request bit clears itself one clock later.

Top module: `sd_data_fifo`

## Requirements
- R1: Words leave in the order they entered, and up to 16 words (DEPTH) can be held at once.
- R2: Status bits 6:0 hold the occupancy in bytes, which is four times the number of stored words, from 0 to 64.
- R3: When `dir_tx`=1, only `reg_wr_en` pushes and only `ctl_pop_en` pops. When `dir_tx`=0, only `ctl_push_en` pushes and only `reg_rd_en` pops. Strobes for the other direction change neither the contents nor the flags.
- R4: The receive flags read as zero when `dir_tx`=1. When `dir_tx`=0, bit 7 is set when 8 or more words are stored, bit 8 is set when 16 words are stored, and bit 12 is set when at least one word is stored.
- R5: The transmit flags read as zero when `dir_tx`=0. When `dir_tx`=1, bit 10 is set when the buffer is empty, bit 11 is set when 8 or fewer words are stored, and bit 13 is set when fewer than 16 words are stored.
- R6: Status bit 9 is set by an accepted controller push with `ctl_last`=1 in receive mode. It stays set until the buffer drains to empty or is flushed, and it reads as zero in transmit mode.
- R7: A push into a full buffer with no pop in the same cycle is dropped. The contents and count stay unchanged, and status bit 14 is set.
- R8: A pop from an empty buffer returns zero on the popping side's data port and sets status bit 15.
- R9: A status write with `stat_wr_ctl[0]`=1 clears bit 14, and one with `stat_wr_ctl[1]`=1 clears bit 15. A new failure event in the same cycle takes precedence over the clear.
- R10: A status write with `stat_wr_ctl[2]`=1 makes bit 16 read 1 for exactly one cycle. During that cycle all push and pop strobes are dropped. At the following edge the buffer empties, and the failure field and the last flag clear.
- R11: After `rst_n` is released, the buffer is empty, the failure field and the last flag are clear, and bits 31:17 always read zero.
- R12: The oldest word is presented combinationally on the popping side's data port (`ctl_pop_data` when transmitting, `reg_rd_data` when receiving). The other side's data port reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_tx | input | 1 | 1 = transmit (software fills), 0 = receive (controller fills) |
| reg_wr_en | input | 1 | Software push strobe |
| reg_wr_data | input | 32 | Software push word |
| reg_rd_en | input | 1 | Software pop strobe |
| reg_rd_data | output | 32 | Oldest word toward software (receive only) |
| ctl_push_en | input | 1 | Controller push strobe |
| ctl_push_data | input | 32 | Controller push word |
| ctl_last | input | 1 | Marks the controller push as the final receive word |
| ctl_pop_en | input | 1 | Controller pop strobe |
| ctl_pop_data | output | 32 | Oldest word toward the controller (transmit only) |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_ctl | input | 3 | Written status bits 16:14: [2] flush, [1] clear underrun, [0] clear overflow |
| stat_rd_data | output | 32 | Status word |

## Verification
The bench fills the buffer exactly to its depth and then pushes once more. A design that let the extra word wrap the write pointer would corrupt the oldest entry; the bench catches this because it expects the drained words to read back unchanged. It pops an empty transmit buffer and expects a zero word with the underrun bit set, which a design that returned stale storage would fail. It issues pushes during the flush cycle and expects them to be lost, and it checks that the flush bit drops after one clock. It drives the wrong-direction strobes and expects no change in count or flags. It steps across the 8-word and 16-word thresholds to expose off-by-one comparisons, and it watches the last-word flag survive a partial drain but clear on the final pop.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    // Status word bit positions (decoded by software, so fixed)
    localparam int ST_CNT_MSB   = 6;
    localparam int ST_RX_HALF   = 7;
    localparam int ST_RX_FULL   = 8;
    localparam int ST_RX_LAST   = 9;
    localparam int ST_TX_EMPTY  = 10;
    localparam int ST_TX_HALF   = 11;
    localparam int ST_RX_AVAIL  = 12;
    localparam int ST_TX_ROOM   = 13;
    localparam int ST_OVF       = 14;
    localparam int ST_UNF       = 15;
    localparam int ST_FLUSH     = 16;

    // Bits of the status write control field (maps to status bits 16:14)
    localparam int WC_CLR_OVF   = 0;
    localparam int WC_CLR_UNF   = 1;
    localparam int WC_FLUSH     = 2;

    typedef struct packed {
        logic unf;
        logic ovf;
    } fail_t;
endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(g))) begin
                word_q[g] <= wdata;
            end
        end
    end

    assign rdata = word_q[raddr];
endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
    import sdf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_tx,
    input  logic          sw_push,
    input  logic          sw_pop,
    input  logic          ctl_push,
    input  logic          ctl_pop,
    input  logic          ctl_last,
    input  logic          clr_ovf,
    input  logic          clr_unf,
    input  logic          flush_req,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          head_valid,
    output logic [CW-1:0] words,
    output fail_t         fail,
    output logic          last_seen,
    output logic          flush_pend
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        fail_t         fail;
        logic          last;
        logic          pend;
    } state_t;

    state_t s_d, s_q;

    logic push_req, pop_req, push_ok, pop_ok;
    logic is_empty, is_full;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        is_empty = (s_q.cnt == '0);
        is_full  = (s_q.cnt == CW'(DEPTH));
        push_req = !s_q.pend && (dir_tx ? sw_push : ctl_push);
        pop_req  = !s_q.pend && (dir_tx ? ctl_pop : sw_pop);
        pop_ok   = pop_req && !is_empty;
        push_ok  = push_req && (!is_full || pop_ok);

        s_d      = s_q;
        s_d.pend = flush_req;

        if (s_q.pend) begin
            s_d.wptr = '0;
            s_d.rptr = '0;
            s_d.cnt  = '0;
            s_d.fail = '0;
            s_d.last = 1'b0;
        end else begin
            if (push_ok) begin
                s_d.wptr = ptr_inc(s_q.wptr);
            end
            if (pop_ok) begin
                s_d.rptr = ptr_inc(s_q.rptr);
            end
            s_d.cnt = s_q.cnt + CW'(push_ok) - CW'(pop_ok);

            // clear first, then let a new event win
            if (clr_ovf) s_d.fail.ovf = 1'b0;
            if (clr_unf) s_d.fail.unf = 1'b0;
            if (push_req && !push_ok) s_d.fail.ovf = 1'b1;
            if (pop_req && is_empty)  s_d.fail.unf = 1'b1;

            if (s_d.cnt == '0) begin
                s_d.last = 1'b0;
            end
            if (push_ok && !dir_tx && ctl_last) begin
                s_d.last = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_en      = push_ok;
    assign wr_addr    = s_q.wptr;
    assign rd_addr    = s_q.rptr;
    assign head_valid = pop_ok;
    assign words      = s_q.cnt;
    assign fail       = s_q.fail;
    assign last_seen  = s_q.last;
    assign flush_pend = s_q.pend;
endmodule

// File: rtl/sdf_stat.sv
module sdf_stat
    import sdf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BYTES = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BCW  = $clog2(DEPTH * BYTES + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic          dir_tx,
    input  logic [CW-1:0] words,
    input  fail_t         fail,
    input  logic          last_seen,
    input  logic          flush_pend,
    output logic [31:0]   status
);
    logic [BCW-1:0] byte_cnt;

    always_comb begin
        byte_cnt = BCW'(words) * BCW'(BYTES);
        status   = '0;
        status[ST_CNT_MSB:0] = 7'(byte_cnt);
        status[ST_RX_HALF]   = !dir_tx && (words >= CW'(HALF));
        status[ST_RX_FULL]   = !dir_tx && (words == CW'(DEPTH));
        status[ST_RX_LAST]   = !dir_tx && last_seen;
        status[ST_RX_AVAIL]  = !dir_tx && (words != '0);
        status[ST_TX_EMPTY]  = dir_tx && (words == '0);
        status[ST_TX_HALF]   = dir_tx && (words <= CW'(HALF));
        status[ST_TX_ROOM]   = dir_tx && (words < CW'(DEPTH));
        status[ST_OVF]       = fail.ovf;
        status[ST_UNF]       = fail.unf;
        status[ST_FLUSH]     = flush_pend;
    end
endmodule

// File: rtl/sd_data_fifo.sv
module sd_data_fifo
    import sdf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BYTES = WIDTH / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_tx,
    input  logic             reg_wr_en,
    input  logic [WIDTH-1:0] reg_wr_data,
    input  logic             reg_rd_en,
    output logic [WIDTH-1:0] reg_rd_data,
    input  logic             ctl_push_en,
    input  logic [WIDTH-1:0] ctl_push_data,
    input  logic             ctl_last,
    input  logic             ctl_pop_en,
    output logic [WIDTH-1:0] ctl_pop_data,
    input  logic             stat_wr_en,
    input  logic [2:0]       stat_wr_ctl,
    output logic [31:0]      stat_rd_data
);
    logic          wr_en, head_valid, last_seen, flush_pend;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] words;
    fail_t         fail;
    logic [WIDTH-1:0] wdata, head;

    sdf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_tx     (dir_tx),
        .sw_push    (reg_wr_en),
        .sw_pop     (reg_rd_en),
        .ctl_push   (ctl_push_en),
        .ctl_pop    (ctl_pop_en),
        .ctl_last   (ctl_last),
        .clr_ovf    (stat_wr_en && stat_wr_ctl[WC_CLR_OVF]),
        .clr_unf    (stat_wr_en && stat_wr_ctl[WC_CLR_UNF]),
        .flush_req  (stat_wr_en && stat_wr_ctl[WC_FLUSH]),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .head_valid (head_valid),
        .words      (words),
        .fail       (fail),
        .last_seen  (last_seen),
        .flush_pend (flush_pend)
    );

    assign wdata = dir_tx ? reg_wr_data : ctl_push_data;

    sdf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (head)
    );

    // head word only on the side that is popping, zero otherwise
    assign reg_rd_data  = (!dir_tx && words != '0) ? head : '0;
    assign ctl_pop_data = ( dir_tx && words != '0) ? head : '0;

    sdf_stat #(.DEPTH(DEPTH), .BYTES(BYTES)) u_stat (
        .dir_tx     (dir_tx),
        .words      (words),
        .fail       (fail),
        .last_seen  (last_seen),
        .flush_pend (flush_pend),
        .status     (stat_rd_data)
    );

    logic unused_hv;
    assign unused_hv = head_valid;
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dir_tx,
    input logic             reg_wr_en,
    input logic             reg_rd_en,
    input logic             ctl_push_en,
    input logic             ctl_pop_en,
    input logic [WIDTH-1:0] reg_rd_data,
    input logic [WIDTH-1:0] ctl_pop_data,
    input logic             stat_wr_en,
    input logic [2:0]       stat_wr_ctl,
    input logic [31:0]      stat_rd_data
);
    localparam logic [6:0] FULL_BYTES = 7'(DEPTH * (WIDTH / 8));

    a_r2_count_align: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_data[1:0] == 2'b00) && (stat_rd_data[6:0] <= FULL_BYTES));

    a_r4_rx_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx |-> (stat_rd_data[9:7] == 3'b000) && !stat_rd_data[12]);

    a_r5_tx_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_tx |-> !stat_rd_data[10] && !stat_rd_data[11] && !stat_rd_data[13]);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_data[6:0] == FULL_BYTES && !stat_rd_data[16] &&
         (dir_tx ? reg_wr_en : ctl_push_en) && !(dir_tx ? ctl_pop_en : reg_rd_en))
        |=> stat_rd_data[14] && $stable(stat_rd_data[6:0]));

    a_r8_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_data[6:0] == 7'd0 && !stat_rd_data[16] &&
         (dir_tx ? ctl_pop_en : reg_rd_en)) |=> stat_rd_data[15]);

    a_r8_underrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_data[6:0] == 7'd0) |-> (reg_rd_data == '0) && (ctl_pop_data == '0));

    a_r10_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_data[16] && !(stat_wr_en && stat_wr_ctl[2]))
        |=> !stat_rd_data[16] && stat_rd_data[6:0] == 7'd0 && stat_rd_data[15:14] == 2'b00);

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_data[31:17] == '0);

    a_r12_idle_side_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx ? (reg_rd_data == '0) : (ctl_pop_data == '0));
endmodule

bind sd_data_fifo sdf_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_tx       (dir_tx),
    .reg_wr_en    (reg_wr_en),
    .reg_rd_en    (reg_rd_en),
    .ctl_push_en  (ctl_push_en),
    .ctl_pop_en   (ctl_pop_en),
    .reg_rd_data  (reg_rd_data),
    .ctl_pop_data (ctl_pop_data),
    .stat_wr_en   (stat_wr_en),
    .stat_wr_ctl  (stat_wr_ctl),
    .stat_rd_data (stat_rd_data)
);

// File: tb/sim_sd_data_fifo.sv
module sim_sd_data_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {dir[75], op[74:72], last[71], data[70:39], exp_rd[38:7], exp_bytes[6:0]}
    // op: 1 software push, 2 controller push, 3 software pop, 4 controller pop
    localparam logic [75:0] VEC [NVEC] = '{
        {1'b0, 3'd2, 1'b0, 32'h1111_1111, 32'h0,          7'd4},
        {1'b0, 3'd2, 1'b1, 32'h2222_2222, 32'h0,          7'd8},
        {1'b0, 3'd3, 1'b0, 32'h0,         32'h1111_1111,  7'd4},
        {1'b0, 3'd3, 1'b0, 32'h0,         32'h2222_2222,  7'd0},
        {1'b1, 3'd1, 1'b0, 32'hA5A5_A5A5, 32'h0,          7'd4},
        {1'b1, 3'd1, 1'b0, 32'h5A5A_5A5A, 32'h0,          7'd8},
        {1'b1, 3'd4, 1'b0, 32'h0,         32'hA5A5_A5A5,  7'd4},
        {1'b1, 3'd4, 1'b0, 32'h0,         32'h5A5A_5A5A,  7'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_tx = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic        ctl_push_en = 1'b0, ctl_pop_en = 1'b0, ctl_last = 1'b0;
    logic [31:0] reg_wr_data = '0, ctl_push_data = '0;
    logic [31:0] reg_rd_data, ctl_pop_data, stat_rd_data;
    logic        stat_wr_en = 1'b0;
    logic [2:0]  stat_wr_ctl = '0;

    int tests = 0;
    int fails = 0;
    logic [31:0] got;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sd_data_fifo u0 (
        .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
        .ctl_push_en(ctl_push_en), .ctl_push_data(ctl_push_data),
        .ctl_last(ctl_last), .ctl_pop_en(ctl_pop_en), .ctl_pop_data(ctl_pop_data),
        .stat_wr_en(stat_wr_en), .stat_wr_ctl(stat_wr_ctl),
        .stat_rd_data(stat_rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one operation; 'val' is the popping side's data seen before the edge
    task automatic do_op(input int op, input logic [31:0] d, input logic lst,
                         output logic [31:0] val);
        @(negedge clk);
        reg_wr_en     = (op == 1);
        ctl_push_en   = (op == 2);
        reg_rd_en     = (op == 3);
        ctl_pop_en    = (op == 4);
        reg_wr_data   = d;
        ctl_push_data = d;
        ctl_last      = lst;
        #1 val = dir_tx ? ctl_pop_data : reg_rd_data;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0; ctl_push_en = 1'b0; reg_rd_en = 1'b0;
        ctl_pop_en = 1'b0; ctl_last = 1'b0;
    endtask

    task automatic wr_stat(input logic [2:0] c);
        @(negedge clk);
        stat_wr_en = 1'b1;
        stat_wr_ctl = c;
        @(posedge clk);
        #1;
        stat_wr_en = 1'b0;
        stat_wr_ctl = '0;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        chk("R11 reset status rx", stat_rd_data, 32'h0000_0000);
        dir_tx = 1'b1;
        #1 chk("R5 R11 reset status tx", stat_rd_data, 32'h0000_2C00);

        // table walk: R1 R2 R12
        for (int i = 0; i < NVEC; i++) begin
            dir_tx = VEC[i][75];
            do_op(int'(VEC[i][74:72]), VEC[i][70:39], VEC[i][71], got);
            if (VEC[i][74:72] >= 3'd3) chk("R12 R1 pop data", got, VEC[i][38:7]);
            chk("R2 byte count", {25'd0, stat_rd_data[6:0]}, {25'd0, VEC[i][6:0]});
        end

        // R3: wrong-direction strobes ignored
        dir_tx = 1'b0;
        do_op(1, 32'hBAD0_0001, 1'b0, got);
        chk("R3 rx ignores software push", stat_rd_data, 32'h0);
        dir_tx = 1'b1;
        do_op(2, 32'hBAD0_0002, 1'b0, got);
        do_op(3, 32'h0, 1'b0, got);
        chk("R3 tx ignores controller push and software pop", stat_rd_data, 32'h0000_2C00);

        // R4 R7 R9 R1: fill receive side past its depth
        dir_tx = 1'b0;
        for (int k = 0; k < 16; k++) begin
            do_op(2, 32'h100 + k, 1'b0, got);
            if (k == 6) chk("R4 rx half below threshold", {31'd0, stat_rd_data[7]}, 32'd0);
            if (k == 7) chk("R4 rx half at 8 words", {31'd0, stat_rd_data[7]}, 32'd1);
            if (k == 14) chk("R4 rx full at 15 words", {31'd0, stat_rd_data[8]}, 32'd0);
        end
        chk("R4 R2 full status", stat_rd_data, 32'h0000_1000 | 32'h180 | 32'd64);
        do_op(2, 32'hDEAD_BEEF, 1'b0, got);
        chk("R7 overflow flagged, count kept", stat_rd_data, 32'h0000_5000 | 32'h180 | 32'd64);
        wr_stat(3'b001);
        chk("R9 overflow cleared", {30'd0, stat_rd_data[15:14]}, 32'd0);
        for (int k = 0; k < 16; k++) begin
            do_op(3, 32'h0, 1'b0, got);
            if (k == 0)  chk("R1 oldest first", got, 32'h100);
            if (k == 15) chk("R7 dropped word absent", got, 32'h10F);
        end
        chk("R4 drained", stat_rd_data, 32'h0);

        // R6: last-word flag
        do_op(2, 32'h0000_0A0A, 1'b0, got);
        do_op(2, 32'h0000_0B0B, 1'b1, got);
        chk("R6 last set", {31'd0, stat_rd_data[9]}, 32'd1);
        do_op(3, 32'h0, 1'b0, got);
        chk("R6 last held after partial drain", {31'd0, stat_rd_data[9]}, 32'd1);
        do_op(3, 32'h0, 1'b0, got);
        chk("R6 last cleared when empty", stat_rd_data, 32'h0);

        // R5: transmit thresholds
        dir_tx = 1'b1;
        for (int k = 0; k < 16; k++) begin
            do_op(1, 32'h200 + k, 1'b0, got);
            if (k == 7)  chk("R5 tx half at 8 words", stat_rd_data, 32'h0000_2800 | 32'd32);
            if (k == 8)  chk("R5 tx half gone at 9 words", stat_rd_data, 32'h0000_2000 | 32'd36);
        end
        chk("R5 tx full", stat_rd_data, 32'd64);

        // R10: flush pulse, strobes during it dropped
        wr_stat(3'b100);
        chk("R10 flush bit high", stat_rd_data, 32'h0001_0000 | 32'd64);
        do_op(1, 32'h0000_0333, 1'b0, got);
        chk("R10 flushed and push dropped", stat_rd_data, 32'h0000_2C00);

        // R8: underrun on empty transmit pop
        do_op(4, 32'h0, 1'b0, got);
        chk("R8 underrun data zero", got, 32'h0);
        chk("R8 underrun flag", stat_rd_data, 32'h0000_AC00);
        wr_stat(3'b010);
        chk("R9 underrun cleared", stat_rd_data, 32'h0000_2C00);

        // R10: flush also clears the failure field and last flag
        dir_tx = 1'b0;
        do_op(3, 32'h0, 1'b0, got);
        do_op(2, 32'h0000_0444, 1'b1, got);
        chk("R8 rx underrun then R6 last", stat_rd_data, 32'h0000_9204);
        wr_stat(3'b100);
        idle();
        chk("R10 flush clears fail and last", stat_rd_data, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule